// File: doc/BRIEF.md
# Punctured Soft-Symbol Depuncturer

This block sits in front of a constraint-length-7, rate-1/2 convolutional (Viterbi) decoder. It takes a stream of demodulated soft I/Q sample pairs and turns them back into one pair of soft branch values per information bit. X is the branch of generator 171 (octal) and Y is the branch of generator 133 (octal). The transmitter punctured the code to a higher rate by deleting some branch bits. This block restores each deleted position as a neutral, zero-confidence soft value and raises an erasure flag for it, so the decoder can ignore it in its branch metrics.

The transmitted bits of one puncturing period are sent in period order, with X before Y within each information bit. They alternate between the I rail and the Q rail, starting on I. Taken together, these rules reproduce the fixed I/Q mapping of every supported rate. The incoming symbols pass through a small holding buffer. Each output needs one or two symbols, so at punctured rates the output rate is higher than the input rate. The block therefore stalls its input through a ready signal. An I/Q swap input resolves spectral inversion, and a new rate code restarts the period.

Top module: `soft_depuncture`

## Requirements
- R1: `rate_sel` selects the keep patterns, written as per-position strings for X / Y: 000 = rate 1/2 (1 / 1), 001 = 2/3 (10 / 11), 010 = 3/4 (101 / 110), 011 = 4/5 (1000 / 1111), 100 = 5/6 (10101 / 11010), 101 = 6/7 (100101 / 111010), 110 = 7/8 (1000101 / 1111010), 111 = 8/9 (10001011 / 11110100). A 1 marks a transmitted position.
- R2: Received soft symbols are taken in the order I, Q, I, Q, and so on. They are assigned to the kept positions in period order, with X before Y within each information bit. The pattern repeats without a gap.
- R3: A deleted position is output as the mid-scale value 1000b with its erasure flag at 1. A kept position has its flag at 0. The two flags are never both 1.
- R4: With `iq_swap` at 1, the I and Q samples of each accepted pair are exchanged before the mapping.
- R5: After a synchronous reset or a rate change, mapping restarts at the first position of the period. Symbols that were buffered before the reset or rate change are discarded.
- R6: In a cycle in which `rate_sel` differs from its value in the previous cycle, `in_ready` is 0. In the following cycle no output is produced.
- R7: A pair is consumed exactly when `in_valid` and `in_ready` are both 1 at a clock edge. `in_ready` is 1 only while the holding buffer has room for a full pair. No accepted symbol is lost or used twice.
- R8: An output is produced in every cycle in which enough symbols are buffered. At rate 1/2, a gapless input gives one output per cycle.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: The first output that depends on a pair accepted at clock edge n becomes valid after edge n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An I/Q sample pair is offered |
| in_ready | output | 1 | The holding buffer can take a pair |
| in_i | input | SW (4) | Soft I sample, offset binary |
| in_q | input | SW (4) | Soft Q sample, offset binary |
| rate_sel | input | 3 | Punctured code rate code |
| iq_swap | input | 1 | Exchange I and Q before mapping |
| out_valid | output | 1 | Output pair is valid |
| out_x | output | SW (4) | Soft value for generator 171 |
| out_y | output | SW (4) | Soft value for generator 133 |
| out_x_era | output | 1 | X position was deleted |
| out_y_era | output | 1 | Y position was deleted |

## Verification
A change of rate code and an offered input pair can fall in the same cycle. At that moment the buffer may also still hold stale symbols that could complete an output. The bench provokes this by raising the new rate together with `in_valid` for the first pair of a segment. It first checks that `in_ready` is low in that cycle. Its scoreboard then requires the outputs to begin at the first period position with that pair, and no stale symbol may reach the output. A second overlap comes from pushes and pops in the same cycle under a continuous stream at rate 7/8. Here the bench counts stall cycles and still demands an exact, in-order output sequence.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int RATE_W = 3;
  localparam int PAT_W  = 8;

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [2:0]        pos_t;

  // keep masks, left aligned: bit PAT_W-1 is period position 0
  function automatic logic [PAT_W-1:0] mask_x(input rate_t r);
    case (r)
      3'd0:    mask_x = 8'b1000_0000;
      3'd1:    mask_x = 8'b1000_0000;
      3'd2:    mask_x = 8'b1010_0000;
      3'd3:    mask_x = 8'b1000_0000;
      3'd4:    mask_x = 8'b1010_1000;
      3'd5:    mask_x = 8'b1001_0100;
      3'd6:    mask_x = 8'b1000_1010;
      default: mask_x = 8'b1000_1011;
    endcase
  endfunction

  function automatic logic [PAT_W-1:0] mask_y(input rate_t r);
    case (r)
      3'd0:    mask_y = 8'b1000_0000;
      3'd1:    mask_y = 8'b1100_0000;
      3'd2:    mask_y = 8'b1100_0000;
      3'd3:    mask_y = 8'b1111_0000;
      3'd4:    mask_y = 8'b1101_0000;
      3'd5:    mask_y = 8'b1110_1000;
      3'd6:    mask_y = 8'b1111_0100;
      default: mask_y = 8'b1111_0100;
    endcase
  endfunction

  // period length is code+1 information bits, so the last position equals the code
  function automatic pos_t last_pos(input rate_t r);
    last_pos = pos_t'(r);
  endfunction

  function automatic logic keep_bit(input logic [PAT_W-1:0] m, input pos_t p);
    logic [2:0] idx;
    idx = 3'(PAT_W-1) - p;
    keep_bit = m[idx];
  endfunction

endpackage

// File: rtl/sdp_hold_buf.sv
module sdp_hold_buf #(
  parameter int SW    = 4,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH+1),
  localparam int FW   = DEPTH*SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [SW-1:0] push_a,
  input  logic [SW-1:0] push_b,
  input  logic [1:0]    pop_n,
  output logic [CW-1:0] count,
  output logic [SW-1:0] head0,
  output logic [SW-1:0] head1
);

  logic [FW-1:0] flat_q, flat_d, shifted, pair_ext;
  logic [CW-1:0] count_d, base;

  assign pair_ext = FW'({push_b, push_a});
  assign base     = count - CW'(pop_n);

  always_comb begin
    shifted = flat_q >> (int'(pop_n) * SW);
    flat_d  = shifted;
    if (push) flat_d = shifted | (pair_ext << (int'(base) * SW));
    count_d = base + (push ? CW'(2) : CW'(0));
    if (flush) begin
      flat_d  = '0;
      count_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flat_q <= '0;
      count  <= '0;
    end else begin
      flat_q <= flat_d;
      count  <= count_d;
    end
  end

  assign head0 = flat_q[SW-1:0];
  assign head1 = flat_q[2*SW-1:SW];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count <= CW'(DEPTH-2)));
  // R8
  pop_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_n) <= count);

endmodule

// File: rtl/sdp_phase_seq.sv
module sdp_phase_seq
  import sdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       advance,
  input  rate_t      rate,
  output logic       keep_x,
  output logic       keep_y,
  output logic [1:0] need
);

  pos_t phase;

  always_ff @(posedge clk) begin
    if (rst || restart)                   phase <= '0;
    else if (advance && phase == last_pos(rate)) phase <= '0;
    else if (advance)                     phase <= phase + pos_t'(1);
  end

  assign keep_x = keep_bit(mask_x(rate), phase);
  assign keep_y = keep_bit(mask_y(rate), phase);
  assign need   = {1'b0, keep_x} + {1'b0, keep_y};

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst || restart)
    phase <= last_pos(rate));
  // R3
  need_nonzero_chk: assert property (@(posedge clk) disable iff (rst || restart)
    need != 2'd0);

endmodule

// File: rtl/sdp_emit.sv
module sdp_emit #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          keep_x,
  input  logic          keep_y,
  input  logic [SW-1:0] head0,
  input  logic [SW-1:0] head1,
  output logic          out_valid,
  output logic [SW-1:0] out_x,
  output logic [SW-1:0] out_y,
  output logic          out_x_era,
  output logic          out_y_era
);

  localparam logic [SW-1:0] MID = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] x_d, y_d;

  always_comb begin
    if (keep_x) begin
      x_d = head0;
      y_d = keep_y ? head1 : MID;
    end else begin
      x_d = MID;
      y_d = head0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_x_era <= 1'b0;
      out_y_era <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_x     <= x_d;
        out_y     <= y_d;
        out_x_era <= !keep_x;
        out_y_era <= !keep_y;
      end
    end
  end

  // R3
  no_double_erase_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_x_era && out_y_era));
  // R3
  erase_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_y_era) |-> (out_y == MID));

endmodule

// File: rtl/soft_depuncture.sv
module soft_depuncture
  import sdp_pkg::*;
#(
  parameter int SW    = 4,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_i,
  input  logic [SW-1:0] in_q,
  input  logic [2:0]    rate_sel,
  input  logic          iq_swap,
  output logic          out_valid,
  output logic [SW-1:0] out_x,
  output logic [SW-1:0] out_y,
  output logic          out_x_era,
  output logic          out_y_era
);

  localparam int CW = $clog2(DEPTH+1);

  rate_t         rate_q;
  logic          rate_chg, push, fire, kx, ky;
  logic [1:0]    need, pop_n;
  logic [CW-1:0] count;
  logic [SW-1:0] sym_a, sym_b, head0, head1;

  always_ff @(posedge clk) rate_q <= rate_sel;

  assign rate_chg = !rst && (rate_sel != rate_q);
  assign in_ready = !rate_chg && (count <= CW'(DEPTH-2));
  assign push     = in_valid && in_ready;
  assign sym_a    = iq_swap ? in_q : in_i;
  assign sym_b    = iq_swap ? in_i : in_q;
  assign fire     = !rate_chg && (count >= CW'(need));
  assign pop_n    = fire ? need : 2'd0;

  sdp_hold_buf #(.SW(SW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .flush(rate_chg), .push(push),
    .push_a(sym_a), .push_b(sym_b), .pop_n(pop_n),
    .count(count), .head0(head0), .head1(head1)
  );

  sdp_phase_seq u_seq (
    .clk(clk), .rst(rst), .restart(rate_chg), .advance(fire),
    .rate(rate_sel), .keep_x(kx), .keep_y(ky), .need(need)
  );

  sdp_emit #(.SW(SW)) u_emit (
    .clk(clk), .rst(rst), .fire(fire), .keep_x(kx), .keep_y(ky),
    .head0(head0), .head1(head1), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y), .out_x_era(out_x_era), .out_y_era(out_y_era)
  );

  // R6
  rate_flush_chk: assert property (@(posedge clk) disable iff (rst)
    rate_chg |=> (count == '0 && !out_valid));
  // R8
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!rate_chg && count >= CW'(2)) |=> out_valid);

endmodule

// File: tb/soft_depuncture_bench.sv
module soft_depuncture_bench;

  typedef struct { logic [3:0] x; logic [3:0] y; logic xe; logic ye; } exp_t;

  logic clk = 0, rst = 1, in_valid = 0, iq_swap = 0;
  logic [3:0] in_i = 0, in_q = 0;
  logic [2:0] rate_sel = 0;
  logic in_ready, out_valid, out_x_era, out_y_era;
  logic [3:0] out_x, out_y;

  int tests = 0, fails = 0, cyc = 0, stalls = 0, first_out = -1, last_out = -1;
  int cur_rate = 0;
  int pi[64], pq[64];
  exp_t expq[$];
  string seg_tag = "R2";

  always #5 clk = ~clk;

  soft_depuncture u_soft_depuncture (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .rate_sel(rate_sel), .iq_swap(iq_swap),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .out_x_era(out_x_era), .out_y_era(out_y_era)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic string xpat(input int r);
    case (r)
      0: return "1";       1: return "10";      2: return "101";      3: return "1000";
      4: return "10101";   5: return "100101";  6: return "1000101";  default: return "10001011";
    endcase
  endfunction

  function automatic string ypat(input int r);
    case (r)
      0: return "1";       1: return "11";      2: return "110";      3: return "1111";
      4: return "11010";   5: return "111010";  6: return "1111010";  default: return "11110100";
    endcase
  endfunction

  // R1 R2 R3 R4: reference mapping computed from the keep strings
  function automatic void build_exp(input int r, input bit sw, input int n);
    int syms[$];
    string xs, ys;
    int pos, idx;
    bit kx, ky;
    exp_t e;
    for (int k = 0; k < n; k++) begin
      syms.push_back(sw ? pq[k] : pi[k]);
      syms.push_back(sw ? pi[k] : pq[k]);
    end
    xs = xpat(r); ys = ypat(r); pos = 0; idx = 0;
    forever begin
      kx = (xs[pos] == 8'h31);
      ky = (ys[pos] == 8'h31);
      if (idx + int'(kx) + int'(ky) > syms.size()) break;
      if (kx) begin e.x = 4'(syms[idx]); e.xe = 0; idx++; end
      else begin e.x = 4'd8; e.xe = 1; end
      if (ky) begin e.y = 4'(syms[idx]); e.ye = 0; idx++; end
      else begin e.y = 4'd8; e.ye = 1; end
      expq.push_back(e);
      pos = (pos + 1) % xs.len();
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", "cycles", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) check(0, "R7", "unexpected output", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        check(out_x == e.x && out_y == e.y, seg_tag, "x/y values",
              int'({out_x, out_y}), int'({e.x, e.y}));
        check(out_x_era == e.xe && out_y_era == e.ye, "R3", "erasure flags",
              int'({out_x_era, out_y_era}), int'({e.xe, e.ye}));
      end
      if (first_out < 0) first_out = cyc;
      last_out = cyc;
    end
  end

  task automatic drive(input int n, input bit gaps, input bit overlap, input int new_rate);
    for (int k = 0; k < n; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin in_valid = 0; @(posedge clk); #1; end
      in_valid = 1; in_i = 4'(pi[k]); in_q = 4'(pq[k]);
      if (overlap && k == 0) begin
        rate_sel = 3'(new_rate);
        @(negedge clk);
        // R6: rate change and offered pair in the same cycle
        check(in_ready == 0, "R6", "in_ready on rate change", int'(in_ready), 0);
        @(posedge clk); #1;
      end
      forever begin
        @(negedge clk);
        if (in_ready) break;
        stalls++;
        @(posedge clk); #1;
      end
      @(posedge clk); #1;
    end
    in_valid = 0;
  endtask

  task automatic segment(input int r, input bit sw, input int n, input bit gaps,
                         input bit overlap, input string tag);
    for (int k = 0; k < n; k++) begin pi[k] = int'($urandom % 16); pq[k] = int'($urandom % 16); end
    build_exp(r, sw, n);
    seg_tag = tag; iq_swap = sw; stalls = 0; first_out = -1; last_out = -1;
    if (!overlap) begin
      if (r == cur_rate) begin rst = 1; @(posedge clk); #1; rst = 0; end
      else begin rate_sel = 3'(r); @(posedge clk); #1; end
      @(posedge clk); #1;
    end
    drive(n, gaps, overlap, r);
    cur_rate = r;
    repeat (8) @(posedge clk); #1;
    // R7: every expected output arrived, none missing
    check(expq.size() == 0, "R7", "outputs left unseen", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    void'($urandom(32'd1993));
    repeat (3) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    // R9
    check(out_valid == 0, "R9", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1, "R9", "in_ready after reset", int'(in_ready), 1);

    // R10: latency of a single pair at rate 1/2
    pi[0] = 5; pq[0] = 12; build_exp(0, 0, 1); seg_tag = "R10";
    @(posedge clk); #1;
    in_valid = 1; in_i = 4'd5; in_q = 4'd12;
    @(negedge clk);
    check(in_ready == 1, "R10", "pair accepted", int'(in_ready), 1);
    @(posedge clk); #1; in_valid = 0;
    @(negedge clk);
    check(out_valid == 0, "R10", "out_valid one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1, "R10", "out_valid two edges after accept", int'(out_valid), 1);
    repeat (3) @(posedge clk); #1;

    // R8: gapless rate 1/2 gives one output per cycle
    segment(0, 0, 16, 0, 0, "R8");
    check(last_out - first_out == 15, "R8", "output span", last_out - first_out, 15);

    // R1 R2: every rate with random gaps
    for (int r = 1; r < 8; r++) segment(r, 0, 21, 1, 0, "R1");
    // R4: swapped rails
    segment(2, 1, 20, 1, 0, "R4");
    segment(6, 1, 19, 0, 0, "R4");
    // R6 overlap, R7 backpressure at 7/8 gapless
    segment(5, 0, 17, 0, 0, "R2");
    segment(6, 0, 30, 0, 1, "R6");
    check(stalls > 0, "R7", "stall cycles at 7/8", stalls, 1);
    // R5: reset with leftovers, same rate
    segment(6, 0, 13, 1, 0, "R5");
    segment(1, 0, 5, 0, 0, "R5");
    segment(1, 0, 7, 1, 0, "R5");
    // R3: erasure-heavy rate 8/9
    segment(7, 0, 25, 0, 1, "R3");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule